// File: doc/BRIEF.md
# BCD Calendar Clock with Update Handshake

This block is the counting core of a real-time clock. It keeps the time of day (seconds, minutes, hours) and the calendar (century, year, month, day of week, day of month) in packed BCD. It steps once for every pulse on a one-pulse-per-second tick input, and it follows BCD carries, month lengths and leap years. The oscillator, the prescaler and any bus protocol wrapper sit outside the block.

Software sees four words through a plain register port: the time word, the calendar word, a control word and a mode word. Writes are single-cycle strobes. Reads are combinational from a read address. To set the clock, software waits for a seconds event and sets one or both stop-request bits in the control word. It then waits for the update-acknowledge flag, writes the new values and clears the request bits. Two sticky status flags, the seconds event and the update acknowledge, are brought out as pins and are cleared by a per-flag clear pulse. A read can land between two counter steps, so software takes a consistent snapshot by reading until two successive reads agree.

The block has no data stream. Every pin is a plain control or status signal, with no valid/ready back-pressure.

Top module: `rtc_bcd_calendar`

## Requirements
- R1: The time word (address 0) holds BCD seconds in bits 6:0, BCD minutes in bits 14:8 and BCD hours in bits 21:16. All other bits read 0. Reset value is 00:00:00 (0x00000000).
- R2: The calendar word (address 1) holds the BCD century in bits 7:0, the BCD year in bits 15:8, the BCD month (01-12) in bits 20:16, the day of week (1-7) in bits 23:21 and the BCD day of month in bits 29:24. Bits 31:30 read 0. Reset value is 1900-01-01 with day of week 1 (0x01210019).
- R3: Each tick on a running time counter adds one second with BCD carries. Seconds go 59 to 00 and carry into minutes, minutes go 59 to 00 and carry into hours, and hours go 23 to 00 and produce a day step.
- R4: A day step on a running calendar does four things. The day of week goes 7 to 1, otherwise it increments. The day of month wraps to 01 after the month's last day: 30 for months 04, 06, 09 and 11, 31 for the other months except February. Month 12 wraps to 01 and increments the year. Year 99 wraps to 00 and increments the century.
- R5: February has 29 days when the year is a nonzero multiple of 4, or when the year is 00 and the century is a multiple of 4. Otherwise it has 28 days.
- R6: Every tick sets the seconds-event flag, frozen or not. The flag stays set until a pulse on clear bit 0. A set and a clear in the same cycle leave the flag set.
- R7: Control word (address 2) bit 0 stops the time counter and bit 1 stops the calendar. While a bit is set, its counter ignores ticks, starting from the cycle after the control write.
- R8: The update-acknowledge flag sets at the first tick after the control word becomes nonzero while no acknowledge is granted. It stays set until a pulse on clear bit 1.
- R9: A write to the time word takes effect only when control bit 0 is set and the acknowledge has been granted. A write to the calendar word likewise needs control bit 1 and the grant. Any other write to these words is ignored.
- R10: Writing 0 to the control word withdraws the grant. Counting then resumes from the written values at the next tick, and a later request needs a fresh tick to be granted again.
- R11: The mode word (address 3) bit 0 reads back as written, with all other bits 0. It resets to 0, and 0 selects 24-hour counting.
- R12: A read returns the addressed word in the same cycle. A write or a tick is visible in the read data from the cycle after the clock edge that captures it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_1hz | input | 1 | One-cycle pulse per second |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 32 | Addressed register contents |
| flag_clr | input | 2 | Bit 0 clears the seconds event, bit 1 clears the update acknowledge |
| sec_evt | output | 1 | Sticky seconds-event flag |
| upd_ack | output | 1 | Sticky update-acknowledge flag |

## Verification
Every result of this block is due one edge after its cause. A tick shows up in the time word, the calendar word and both flags after the capturing edge. A register write shows up in the read data after its edge. A flag clear takes effect at the edge that captures it. The bench drives every strobe for one full cycle between falling edges and samples the combinational read data 1 ns after the next falling edge, so each check lands exactly one edge after its stimulus. Freeze and ignored-write cases are checked by reading the affected word back before the next stimulus, and the table-driven rollovers are checked after the last tick of each vector.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  localparam int DATA_W = 32;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    ADDR_TIME = 2'd0,
    ADDR_CAL  = 2'd1,
    ADDR_CTRL = 2'd2,
    ADDR_MODE = 2'd3
  } reg_addr_e;

  typedef struct packed {
    logic [5:0] hour;
    logic [6:0] min;
    logic [6:0] sec;
  } clk_time_t;

  typedef struct packed {
    logic [5:0] mday;
    logic [2:0] wday;
    logic [4:0] month;
    logic [7:0] year;
    logic [7:0] cent;
  } clk_cal_t;

  function automatic logic [7:0] bcd_next(input logic [7:0] v);
    logic [7:0] r;
    if (v[3:0] == 4'h9) r = {v[7:4] + 4'h1, 4'h0};
    else                r = {v[7:4], v[3:0] + 4'h1};
    return r;
  endfunction

  function automatic logic [7:0] bcd_to_bin(input logic [7:0] v);
    return ({4'h0, v[7:4]} * 8'd10) + {4'h0, v[3:0]};
  endfunction

  function automatic logic [DATA_W-1:0] time_to_word(input clk_time_t t);
    return {10'b0, t.hour, 1'b0, t.min, 1'b0, t.sec};
  endfunction

  function automatic clk_time_t word_to_time(input logic [DATA_W-1:0] w);
    clk_time_t t;
    t.sec  = w[6:0];
    t.min  = w[14:8];
    t.hour = w[21:16];
    return t;
  endfunction

  function automatic logic [DATA_W-1:0] cal_to_word(input clk_cal_t c);
    return {2'b0, c.mday, c.wday, c.month, c.year, c.cent};
  endfunction

  function automatic clk_cal_t word_to_cal(input logic [DATA_W-1:0] w);
    clk_cal_t c;
    c.cent  = w[7:0];
    c.year  = w[15:8];
    c.month = w[20:16];
    c.wday  = w[23:21];
    c.mday  = w[29:24];
    return c;
  endfunction

  function automatic logic leap_year(input logic [7:0] cent, input logic [7:0] year);
    logic [7:0] yb;
    logic [7:0] cb;
    yb = bcd_to_bin(year);
    cb = bcd_to_bin(cent);
    if (year == 8'h00) return (cb[1:0] == 2'b00);
    return (yb[1:0] == 2'b00);
  endfunction

  function automatic logic [5:0] month_last_day(input logic [4:0] month, input logic leap);
    logic [5:0] d;
    case (month)
      5'h02:                      d = leap ? 6'h29 : 6'h28;
      5'h04, 5'h06, 5'h09, 5'h11: d = 6'h30;
      default:                    d = 6'h31;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/rtc_time_count.sv
module rtc_time_count
  import rtc_pkg::*;
#(
  parameter logic [5:0] RST_HOUR = 6'h00,
  parameter logic [6:0] RST_MIN  = 7'h00,
  parameter logic [6:0] RST_SEC  = 7'h00
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      tick,
  input  logic      stop,
  input  logic      load,
  input  clk_time_t load_val,
  output clk_time_t now,
  output logic      day_step
);

  clk_time_t cur_q;
  clk_time_t cur_d;
  logic      adv;
  logic      sec_last;
  logic      min_last;
  logic      hour_last;
  logic [7:0] sec_inc;
  logic [7:0] min_inc;
  logic [7:0] hour_inc;

  assign adv       = tick && !stop;
  assign sec_last  = (cur_q.sec  == 7'h59);
  assign min_last  = (cur_q.min  == 7'h59);
  assign hour_last = (cur_q.hour == 6'h23);
  assign sec_inc   = bcd_next({1'b0, cur_q.sec});
  assign min_inc   = bcd_next({1'b0, cur_q.min});
  assign hour_inc  = bcd_next({2'b0, cur_q.hour});

  always_comb begin
    cur_d = cur_q;
    if (load) begin
      cur_d = load_val;
    end else if (adv) begin
      if (!sec_last) begin
        cur_d.sec = sec_inc[6:0];
      end else begin
        cur_d.sec = 7'h00;
        if (!min_last) begin
          cur_d.min = min_inc[6:0];
        end else begin
          cur_d.min = 7'h00;
          cur_d.hour = hour_last ? 6'h00 : hour_inc[5:0];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cur_q <= '{hour: RST_HOUR, min: RST_MIN, sec: RST_SEC};
    else        cur_q <= cur_d;
  end

  assign now      = cur_q;
  assign day_step = adv && sec_last && min_last && hour_last;

  // R3, R7: without a tick that counts and without a load, the time holds
  a_r7_time_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !(tick && !stop)) |=> $stable(cur_q));

  // R3: a day step leaves the time at midnight
  a_r3_midnight_after_step: assert property (@(posedge clk) disable iff (!rst_n)
    (day_step && !load) |=> (now == '0));

endmodule

// File: rtl/rtc_cal_count.sv
module rtc_cal_count
  import rtc_pkg::*;
#(
  parameter logic [7:0] RST_CENT  = 8'h19,
  parameter logic [7:0] RST_YEAR  = 8'h00,
  parameter logic [4:0] RST_MONTH = 5'h01,
  parameter logic [2:0] RST_WDAY  = 3'd1,
  parameter logic [5:0] RST_MDAY  = 6'h01
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     day_step,
  input  logic     stop,
  input  logic     load,
  input  clk_cal_t load_val,
  output clk_cal_t now
);

  clk_cal_t   cal_q;
  clk_cal_t   cal_d;
  logic       step;
  logic       leap;
  logic [5:0] last_day;
  logic [7:0] mday_inc;
  logic [7:0] month_inc;
  logic [7:0] year_inc;
  logic [7:0] cent_inc;

  assign step      = day_step && !stop;
  assign leap      = leap_year(cal_q.cent, cal_q.year);
  assign last_day  = month_last_day(cal_q.month, leap);
  assign mday_inc  = bcd_next({2'b0, cal_q.mday});
  assign month_inc = bcd_next({3'b0, cal_q.month});
  assign year_inc  = bcd_next(cal_q.year);
  assign cent_inc  = bcd_next(cal_q.cent);

  always_comb begin
    cal_d = cal_q;
    if (load) begin
      cal_d = load_val;
    end else if (step) begin
      cal_d.wday = (cal_q.wday == 3'd7) ? 3'd1 : cal_q.wday + 3'd1;
      if (cal_q.mday != last_day) begin
        cal_d.mday = mday_inc[5:0];
      end else begin
        cal_d.mday = 6'h01;
        if (cal_q.month != 5'h12) begin
          cal_d.month = month_inc[4:0];
        end else begin
          cal_d.month = 5'h01;
          if (cal_q.year != 8'h99) begin
            cal_d.year = year_inc;
          end else begin
            cal_d.year = 8'h00;
            cal_d.cent = (cal_q.cent == 8'h99) ? 8'h00 : cent_inc;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cal_q <= '{mday: RST_MDAY, wday: RST_WDAY, month: RST_MONTH,
                           year: RST_YEAR, cent: RST_CENT};
    else        cal_q <= cal_d;
  end

  assign now = cal_q;

  // R4, R7: no step and no load means the calendar holds
  a_r4_cal_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !step) |=> $stable(cal_q));

  // R4: a step always moves the day of week
  a_r4_wday_moves: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load) |=> (cal_q.wday != $past(cal_q.wday)));

endmodule

// File: rtl/rtc_update_ctrl.sv
module rtc_update_ctrl
  import rtc_pkg::*;
#(
  parameter int REQ_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             ctrl_wr,
  input  logic             mode_wr,
  input  logic [REQ_W-1:0] wr_bits,
  input  logic [1:0]       flag_clr,
  output logic [REQ_W-1:0] req,
  output logic             granted,
  output logic             mode_bit,
  output logic             sec_evt,
  output logic             upd_ack
);

  logic [REQ_W-1:0] req_q;
  logic             granted_q;
  logic             mode_q;
  logic             sec_q;
  logic             ack_q;
  logic             grant_now;

  assign grant_now = tick && (req_q != '0) && !granted_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q     <= '0;
      granted_q <= 1'b0;
      mode_q    <= 1'b0;
      sec_q     <= 1'b0;
      ack_q     <= 1'b0;
    end else begin
      if (ctrl_wr) req_q  <= wr_bits;
      if (mode_wr) mode_q <= wr_bits[0];
      if (req_q == '0)    granted_q <= 1'b0;
      else if (grant_now) granted_q <= 1'b1;
      if (tick)             sec_q <= 1'b1;
      else if (flag_clr[0]) sec_q <= 1'b0;
      if (grant_now)        ack_q <= 1'b1;
      else if (flag_clr[1]) ack_q <= 1'b0;
    end
  end

  assign req      = req_q;
  assign granted  = granted_q;
  assign mode_bit = mode_q;
  assign sec_evt  = sec_q;
  assign upd_ack  = ack_q;

  // R6: a tick always leaves the seconds flag set
  a_r6_sec_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> sec_evt);

  // R8: the acknowledge only rises on a tick
  a_r8_ack_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(upd_ack) |-> $past(tick));

  // R10: an empty request withdraws the grant
  a_r10_grant_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (req == '0) |=> !granted);

endmodule

// File: rtl/rtc_bcd_calendar.sv
module rtc_bcd_calendar
  import rtc_pkg::*;
#(
  parameter logic [7:0] RST_CENT = 8'h19,
  parameter logic [7:0] RST_YEAR = 8'h00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_1hz,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic [1:0]        flag_clr,
  output logic              sec_evt,
  output logic              upd_ack
);

  localparam int REQ_W = 2;
  localparam int REQ_TIME = 0;
  localparam int REQ_CAL  = 1;

  logic [REQ_W-1:0] req;
  logic             granted;
  logic             mode_bit;
  logic             time_load;
  logic             cal_load;
  logic             day_step;
  clk_time_t        time_now;
  clk_cal_t         cal_now;

  assign time_load = wr_en && (wr_addr == ADDR_TIME) && req[REQ_TIME] && granted;
  assign cal_load  = wr_en && (wr_addr == ADDR_CAL)  && req[REQ_CAL]  && granted;

  rtc_update_ctrl #(.REQ_W(REQ_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick_1hz),
    .ctrl_wr  (wr_en && (wr_addr == ADDR_CTRL)),
    .mode_wr  (wr_en && (wr_addr == ADDR_MODE)),
    .wr_bits  (wr_data[REQ_W-1:0]),
    .flag_clr (flag_clr),
    .req      (req),
    .granted  (granted),
    .mode_bit (mode_bit),
    .sec_evt  (sec_evt),
    .upd_ack  (upd_ack)
  );

  rtc_time_count u_time (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick_1hz),
    .stop     (req[REQ_TIME]),
    .load     (time_load),
    .load_val (word_to_time(wr_data)),
    .now      (time_now),
    .day_step (day_step)
  );

  rtc_cal_count #(.RST_CENT(RST_CENT), .RST_YEAR(RST_YEAR)) u_cal (
    .clk      (clk),
    .rst_n    (rst_n),
    .day_step (day_step),
    .stop     (req[REQ_CAL]),
    .load     (cal_load),
    .load_val (word_to_cal(wr_data)),
    .now      (cal_now)
  );

  always_comb begin
    case (rd_addr)
      ADDR_TIME: rd_data = time_to_word(time_now);
      ADDR_CAL:  rd_data = cal_to_word(cal_now);
      ADDR_CTRL: rd_data = {{(DATA_W-REQ_W){1'b0}}, req};
      default:   rd_data = {{(DATA_W-1){1'b0}}, mode_bit};
    endcase
  end

  // R9: a time write without request and grant leaves the time frozen or counting only
  a_r9_time_write_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_addr == ADDR_TIME) && req[REQ_TIME] && !granted)
      |=> $stable(time_now));

  // R7: a stopped calendar does not move unless loaded
  a_r7_cal_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (req[REQ_CAL] && !cal_load) |=> $stable(cal_now));

endmodule

// File: tb/rtc_bcd_calendar_tb_top.sv
module rtc_bcd_calendar_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_1hz = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [1:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic [1:0]  flag_clr = '0;
  logic        sec_evt;
  logic        upd_ack;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  rtc_bcd_calendar dut_i (
    .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .flag_clr(flag_clr), .sec_evt(sec_evt), .upd_ack(upd_ack)
  );

  function automatic logic [31:0] mk_cal(input logic [7:0] cent, input logic [7:0] yr,
                                         input logic [4:0] mon, input logic [2:0] wd,
                                         input logic [5:0] md);
    return {2'b0, md, wd, mon, yr, cent};
  endfunction

  typedef struct packed {
    logic [31:0] t_in;
    logic [31:0] c_in;
    logic [7:0]  n;
    logic [31:0] t_exp;
    logic [31:0] c_exp;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{32'h00000058, mk_cal(8'h19,8'h00,5'h01,3'd1,6'h01), 8'd3, 32'h00000101, mk_cal(8'h19,8'h00,5'h01,3'd1,6'h01)},
    '{32'h00095959, mk_cal(8'h19,8'h00,5'h01,3'd1,6'h01), 8'd1, 32'h00100000, mk_cal(8'h19,8'h00,5'h01,3'd1,6'h01)},
    '{32'h00235959, mk_cal(8'h20,8'h23,5'h04,3'd7,6'h30), 8'd1, 32'h00000000, mk_cal(8'h20,8'h23,5'h05,3'd1,6'h01)},
    '{32'h00235959, mk_cal(8'h20,8'h23,5'h02,3'd3,6'h28), 8'd1, 32'h00000000, mk_cal(8'h20,8'h23,5'h03,3'd4,6'h01)},
    '{32'h00235959, mk_cal(8'h20,8'h24,5'h02,3'd3,6'h28), 8'd1, 32'h00000000, mk_cal(8'h20,8'h24,5'h02,3'd4,6'h29)},
    '{32'h00235959, mk_cal(8'h19,8'h00,5'h02,3'd3,6'h28), 8'd1, 32'h00000000, mk_cal(8'h19,8'h00,5'h03,3'd4,6'h01)},
    '{32'h00235959, mk_cal(8'h20,8'h00,5'h02,3'd3,6'h28), 8'd1, 32'h00000000, mk_cal(8'h20,8'h00,5'h02,3'd4,6'h29)},
    '{32'h00235959, mk_cal(8'h19,8'h99,5'h12,3'd5,6'h31), 8'd1, 32'h00000000, mk_cal(8'h20,8'h00,5'h01,3'd6,6'h01)},
    '{32'h00235959, mk_cal(8'h20,8'h23,5'h01,3'd2,6'h31), 8'd1, 32'h00000000, mk_cal(8'h20,8'h23,5'h02,3'd3,6'h01)},
    '{32'h00225959, mk_cal(8'h20,8'h24,5'h02,3'd4,6'h29), 8'd1, 32'h00230000, mk_cal(8'h20,8'h24,5'h02,3'd4,6'h29)},
    '{32'h00235959, mk_cal(8'h20,8'h24,5'h02,3'd4,6'h29), 8'd1, 32'h00000000, mk_cal(8'h20,8'h24,5'h03,3'd5,6'h01)}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic reg_rd(input logic [1:0] a, output logic [31:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic pulse_tick();
    @(negedge clk);
    tick_1hz = 1'b1;
    @(negedge clk);
    tick_1hz = 1'b0;
  endtask

  task automatic clear_flags();
    @(negedge clk);
    flag_clr = 2'b11;
    @(negedge clk);
    flag_clr = 2'b00;
  endtask

  task automatic set_clock(input logic [31:0] t, input logic [31:0] c);
    clear_flags();
    reg_wr(2'd2, 32'd3);
    pulse_tick();
    check("R8 ack after request tick", {31'b0, upd_ack}, 32'd1);
    reg_wr(2'd0, t);
    reg_wr(2'd1, c);
    reg_wr(2'd2, 32'd0);
    clear_flags();
  endtask

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // Reset state
    reg_rd(2'd0, v); check("R1 reset time", v, 32'h00000000);
    reg_rd(2'd1, v); check("R2 reset calendar", v, 32'h01210019);
    reg_rd(2'd2, v); check("R7 reset control", v, 32'h0);
    reg_rd(2'd3, v); check("R11 reset mode", v, 32'h0);
    check("R6 reset sec flag", {31'b0, sec_evt}, 32'd0);
    check("R8 reset ack flag", {31'b0, upd_ack}, 32'd0);

    // Table-driven rollovers (R3, R4, R5)
    for (int i = 0; i < NV; i++) begin
      set_clock(VECS[i].t_in, VECS[i].c_in);
      for (int k = 0; k < int'(VECS[i].n); k++) pulse_tick();
      reg_rd(2'd0, v); check($sformatf("R3 vector %0d time", i), v, VECS[i].t_exp);
      reg_rd(2'd1, v); check($sformatf("R4 R5 vector %0d calendar", i), v, VECS[i].c_exp);
    end

    // Time-only update handshake
    set_clock(32'h00100000, 32'h01210019);
    reg_wr(2'd2, 32'd1);
    check("R10 no ack before tick", {31'b0, upd_ack}, 32'd0);
    reg_wr(2'd0, 32'h00111111);
    reg_rd(2'd0, v); check("R9 time write ignored before grant", v, 32'h00100000);
    pulse_tick();
    check("R8 ack set", {31'b0, upd_ack}, 32'd1);
    reg_rd(2'd0, v); check("R7 time frozen at grant tick", v, 32'h00100000);
    reg_wr(2'd1, mk_cal(8'h20,8'h24,5'h02,3'd4,6'h29));
    reg_rd(2'd1, v); check("R9 calendar write ignored without its bit", v, 32'h01210019);
    reg_wr(2'd0, 32'h00235959);
    reg_rd(2'd0, v); check("R12 R9 time write visible next cycle", v, 32'h00235959);
    clear_flags();
    pulse_tick();
    reg_rd(2'd0, v); check("R7 time ignores tick", v, 32'h00235959);
    check("R6 sec flag while frozen", {31'b0, sec_evt}, 32'd1);
    reg_wr(2'd2, 32'd0);
    pulse_tick();
    reg_rd(2'd0, v); check("R10 resume from written time", v, 32'h00000000);
    reg_rd(2'd1, v); check("R4 day step after resume", v, mk_cal(8'h19,8'h00,5'h01,3'd2,6'h02));

    // Calendar-only update
    clear_flags();
    check("R6 sec flag cleared", {31'b0, sec_evt}, 32'd0);
    check("R8 ack flag cleared", {31'b0, upd_ack}, 32'd0);
    reg_wr(2'd2, 32'd2);
    check("R10 fresh request waits for tick", {31'b0, upd_ack}, 32'd0);
    pulse_tick();
    check("R8 ack for calendar request", {31'b0, upd_ack}, 32'd1);
    reg_rd(2'd0, v); check("R7 time still counts", v, 32'h00000001);
    reg_wr(2'd0, 32'h00050505);
    reg_rd(2'd0, v); check("R9 time write ignored without its bit", v, 32'h00000001);
    reg_wr(2'd1, mk_cal(8'h20,8'h24,5'h02,3'd4,6'h29));
    reg_rd(2'd1, v); check("R9 calendar write taken", v, mk_cal(8'h20,8'h24,5'h02,3'd4,6'h29));
    reg_rd(2'd2, v); check("R7 control readback", v, 32'd2);
    pulse_tick();
    reg_rd(2'd0, v); check("R3 time counts once", v, 32'h00000002);
    reg_wr(2'd2, 32'd0);

    // Flag set wins over clear
    @(negedge clk);
    tick_1hz = 1'b1; flag_clr = 2'b01;
    @(negedge clk);
    tick_1hz = 1'b0; flag_clr = 2'b00;
    check("R6 set wins over clear", {31'b0, sec_evt}, 32'd1);

    // Mode register
    reg_wr(2'd3, 32'hFFFF_FFFF);
    reg_rd(2'd3, v); check("R11 mode bit readback", v, 32'd1);
    reg_wr(2'd3, 32'd0);
    reg_rd(2'd3, v); check("R11 mode 24-hour", v, 32'd0);

    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule